// File: doc/BRIEF.md
# Label Acceptance Filter

This block sits between a serial word receiver and its receive buffer and decides, word by word, whether a freshly received 32-bit word is stored or dropped. The decision depends on the word's 8-bit label in bits [7:0]. A 256-bit acceptance map holds one bit for each possible label. When filtering is switched on, a word whose map bit is 1 is forwarded and a word whose map bit is 0 is dropped. When filtering is switched off, every valid word is forwarded.

A host maintains the map through simple register-style ports. It can write a single bit by label number, write one byte covering eight consecutive labels, or fill the whole map with all zeros or all ones. It can read the map back one byte at a time. A separate enable register turns filtering on and off. The accept decision is made in the same cycle as the incoming valid strobe, and the qualified strobe and word reach the receive buffer one cycle later. A dropped word leaves the output strobe and the output word untouched.

Top module: `label_accept_filter`

## Requirements
- R1: After reset every map bit is 0, filtering is off, `out_valid` is 0 and `out_word` is 0.
- R2: With filtering on, a word presented with `in_valid` is forwarded on `out_valid`/`out_word` in the next cycle exactly when the map bit indexed by its bits [7:0] is 1.
- R3: With filtering off, every word presented with `in_valid` is forwarded unchanged in the next cycle.
- R4: A dropped word, or a cycle without `in_valid`, gives `out_valid` = 0 in the next cycle and leaves `out_word` at its previous value.
- R5: A single-bit write sets map bit `bit_addr` to `bit_val` from the next cycle on.
- R6: A byte write to index k places `byte_data` bit i into the map bit for label 8k+i, for i = 0 to 7.
- R7: A fill write sets all 256 map bits to `fill_val`.
- R8: When several writes occur in the same cycle, the fill is applied first, then the byte write, then the bit write, so a later kind wins wherever they overlap.
- R9: `rd_data` bit i shows the map bit for label 8*`rd_idx`+i, combinationally from the current map contents.
- R10: A word arriving in the same cycle as a map write or an enable write is judged with the map and enable values from before that write.
- R11: An enable write loads `en_din` into the filter enable, which takes effect for words arriving in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Load strobe for the filter enable |
| en_din | input | 1 | New filter enable value |
| fill_wr | input | 1 | Fill the whole map |
| fill_val | input | 1 | Value written to every map bit on a fill |
| byte_wr | input | 1 | Byte write strobe |
| byte_idx | input | 5 | Byte index k, labels 8k to 8k+7 |
| byte_data | input | 8 | Byte value, bit i for label 8k+i |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Label number to write |
| bit_val | input | 1 | Bit value to write |
| rd_idx | input | 5 | Byte index to read back |
| rd_data | output | 8 | Map byte selected by rd_idx |
| in_valid | input | 1 | Incoming word valid |
| in_word | input | 32 | Incoming word, label in bits [7:0] |
| out_valid | output | 1 | Qualified write strobe to the receive buffer |
| out_word | output | 32 | Forwarded word |

## Verification
A corrupted map bit shows at the ports in two ways: the readback of its byte differs at once, and the next word carrying that label is wrongly kept or dropped one cycle after it arrives. The bench therefore compares the readback byte on every cycle and sweeps all 32 bytes after each phase, so a bad bit cannot stay hidden until traffic happens to use its label. A wrong enable value shows up only on the first word whose map bit is 0. For that reason words with both accepted and rejected labels are sent in every phase, including in the same cycle as writes, which exposes the write-versus-lookup ordering.

// File: rtl/lbl_filt_pkg.sv
package lbl_filt_pkg;
  localparam int unsigned WORD_W_DEF  = 32;
  localparam int unsigned LABEL_W_DEF = 8;
  localparam int unsigned BYTE_W_DEF  = 8;

  // Position of bit i within map byte k.
  function automatic int unsigned map_pos(input int unsigned k, input int unsigned i,
                                          input int unsigned byte_w);
    return k * byte_w + i;
  endfunction
endpackage

// File: rtl/lbl_map_store.sv
module lbl_map_store
  import lbl_filt_pkg::*;
#(
  parameter int unsigned LABEL_W = LABEL_W_DEF,
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  localparam int unsigned NUM_LBL = 1 << LABEL_W,
  localparam int unsigned NUM_BYT = NUM_LBL / BYTE_W,
  localparam int unsigned BIDX_W  = $clog2(NUM_BYT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_wr,
  input  logic               fill_val,
  input  logic               byte_wr,
  input  logic [BIDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               bit_wr,
  input  logic [LABEL_W-1:0] bit_addr,
  input  logic               bit_val,
  input  logic [BIDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic [LABEL_W-1:0] look_label,
  output logic               look_hit
);
  logic [NUM_LBL-1:0] map_q, map_d;

  // Writes in fixed order: fill, then byte, then bit.
  always_comb begin
    map_d = map_q;
    if (fill_wr) map_d = {NUM_LBL{fill_val}};
    if (byte_wr)
      for (int i = 0; i < int'(BYTE_W); i++)
        map_d[map_pos(int'(byte_idx), i, BYTE_W)] = byte_data[i];
    if (bit_wr) map_d[bit_addr] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;

  generate
    for (genvar g = 0; g < int'(BYTE_W); g++) begin : g_rd
      assign rd_data[g] = map_q[map_pos(int'(rd_idx), g, BYTE_W)];
    end
  endgenerate

  // Lookup uses the registered map: a same-cycle write is not yet visible.
  assign look_hit = map_q[look_label];

  logic wr_any;
  assign wr_any = fill_wr | byte_wr | bit_wr;

  AST_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> map_q[$past(bit_addr)] == $past(bit_val)); // R5
  AST_FILL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && !byte_wr && !bit_wr) |=> ($countones(map_q) == ($past(fill_val) ? NUM_LBL : 0))); // R7
  AST_BYTE_OVER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && byte_wr && !bit_wr) |=>
      map_q[map_pos(int'($past(byte_idx)), 0, BYTE_W)] == $past(byte_data[0])); // R8
  AST_MAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(map_q)); // R10
endmodule

// File: rtl/lbl_decide.sv
module lbl_decide
  import lbl_filt_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned LABEL_W = LABEL_W_DEF
) (
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               filt_on,
  input  logic               look_hit,
  output logic [LABEL_W-1:0] label,
  output logic               accept
);
  assign label  = in_word[LABEL_W-1:0];
  assign accept = in_valid & (~filt_on | look_hit);
endmodule

// File: rtl/label_accept_filter.sv
module label_accept_filter
  import lbl_filt_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned LABEL_W = LABEL_W_DEF,
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  localparam int unsigned NUM_LBL = 1 << LABEL_W,
  localparam int unsigned BIDX_W  = $clog2(NUM_LBL / BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               en_din,
  input  logic               fill_wr,
  input  logic               fill_val,
  input  logic               byte_wr,
  input  logic [BIDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               bit_wr,
  input  logic [LABEL_W-1:0] bit_addr,
  input  logic               bit_val,
  input  logic [BIDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word
);
  logic               filt_on_q;
  logic [LABEL_W-1:0] label;
  logic               look_hit;
  logic               accept;

  lbl_map_store #(.LABEL_W(LABEL_W), .BYTE_W(BYTE_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .fill_wr(fill_wr), .fill_val(fill_val),
    .byte_wr(byte_wr), .byte_idx(byte_idx), .byte_data(byte_data),
    .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .look_label(label), .look_hit(look_hit)
  );

  lbl_decide #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) i_decide (
    .in_valid(in_valid), .in_word(in_word), .filt_on(filt_on_q),
    .look_hit(look_hit), .label(label), .accept(accept)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     filt_on_q <= 1'b0;
    else if (en_wr) filt_on_q <= en_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) out_word <= in_word;
    end

  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filt_on_q) |=> (out_valid && out_word == $past(in_word))); // R3
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_on_q && !look_hit) |=> (!out_valid && $stable(out_word))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word))); // R4
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> filt_on_q == $past(en_din)); // R11
endmodule

// File: tb/test_label_accept_filter.sv
`timescale 1ns/1ps
module test_label_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 0, en_din = 0, fill_wr = 0, fill_val = 0;
  logic        byte_wr = 0, bit_wr = 0, bit_val = 0, in_valid = 0;
  logic [4:0]  byte_idx = '0, rd_idx = '0;
  logic [7:0]  byte_data = '0, bit_addr = '0, rd_data;
  logic [31:0] in_word = '0, out_word;
  logic        out_valid;

  always #5 clk = ~clk;

  label_accept_filter i_label_accept_filter (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_din(en_din),
    .fill_wr(fill_wr), .fill_val(fill_val), .byte_wr(byte_wr), .byte_idx(byte_idx),
    .byte_data(byte_data), .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val),
    .rd_idx(rd_idx), .rd_data(rd_data), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit ref_map [256];
  bit ref_en = 0;
  bit exp_v = 0;
  logic [31:0] exp_w = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_byte(input int k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ref_map[k * 8 + i];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      foreach (ref_map[i]) ref_map[i] = 0;
      ref_en = 0; exp_v = 0; exp_w = '0;
    end else begin
      exp_v = in_valid && (!ref_en || ref_map[in_word[7:0]]); // R10: old state
      if (exp_v) exp_w = in_word;
      if (fill_wr) foreach (ref_map[i]) ref_map[i] = fill_val;
      if (byte_wr) for (int i = 0; i < 8; i++) ref_map[byte_idx * 8 + i] = byte_data[i];
      if (bit_wr) ref_map[bit_addr] = bit_val;
      if (en_wr) ref_en = en_din;
    end
    @(negedge clk);
    chk("R2/R3 out_valid", {31'd0, out_valid}, {31'd0, exp_v});
    chk("R4 out_word", out_word, exp_w);
    chk("R9 readback", {24'd0, rd_data}, {24'd0, ref_byte(rd_idx)});
  endtask

  task automatic clear_in();
    en_wr = 0; fill_wr = 0; byte_wr = 0; bit_wr = 0; in_valid = 0;
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 32; k++) begin
      rd_idx = k[4:0];
      #1;
      chk(tag, {24'd0, rd_data}, {24'd0, ref_byte(k)});
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1; in_word = w; tick(); clear_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    // R1: reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 out_word", out_word, 32'd0);
    sweep("R1 map zero");
    tick();

    // R3: filtering off, all words pass
    send(32'h1234_5600); send(32'hDEAD_BEFF); send(32'h0000_0080);

    // R11: enable on; R2: empty map drops everything, R4 word held
    en_wr = 1; en_din = 1; tick(); clear_in();
    send(32'hAAAA_5511); send(32'h0F0F_F0FF);
    chk("R4 held word", out_word, 32'h0000_0080);

    // R6: byte 3 = A5 -> labels 24,26,29,31 accepted
    byte_wr = 1; byte_idx = 5'd3; byte_data = 8'hA5; tick(); clear_in();
    for (int l = 24; l < 32; l++) send({24'hC0FFEE, l[7:0]});
    rd_idx = 5'd3; #1; chk("R6 byte readback", {24'd0, rd_data}, 32'h0000_00A5);

    // R5: single bit writes
    bit_wr = 1; bit_addr = 8'd255; bit_val = 1; tick(); clear_in();
    bit_wr = 1; bit_addr = 8'd26;  bit_val = 0; tick(); clear_in();
    send(32'h7777_77FF); send(32'h7777_771A);
    sweep("R5 map after bit writes");

    // R7 and R8: fill ones, then fill zero with byte and bit overlapping
    fill_wr = 1; fill_val = 1; tick(); clear_in();
    sweep("R7 fill ones");
    fill_wr = 1; fill_val = 0; byte_wr = 1; byte_idx = 5'd10; byte_data = 8'h3C;
    bit_wr = 1; bit_addr = 8'd82; bit_val = 0; tick(); clear_in();
    rd_idx = 5'd10; #1; chk("R8 priority byte 10", {24'd0, rd_data}, 32'h0000_0038);
    sweep("R8 map after combined write");

    // R10: word with simultaneous write to its own label, then enable change
    in_valid = 1; in_word = 32'h5555_5590; bit_wr = 1; bit_addr = 8'h90; bit_val = 1;
    tick(); clear_in();
    send(32'h5555_5590);
    in_valid = 1; in_word = 32'h1111_1101; en_wr = 1; en_din = 0; tick(); clear_in();
    send(32'h1111_1101);

    // Mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      en_wr = (r[3:0] == 4'd0); en_din = r[4];
      fill_wr = (r[9:5] == 5'd0); fill_val = r[10];
      byte_wr = r[11] & r[12]; byte_idx = 5'($urandom); byte_data = 8'($urandom);
      bit_wr = r[13]; bit_addr = 8'($urandom); bit_val = r[14];
      in_valid = r[15] | r[16]; in_word = $urandom;
      rd_idx = 5'($urandom);
      tick();
    end
    clear_in();
    tick();
    sweep("R9 final sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule